// File: doc/BRIEF.md
# Timer Master Trigger Output Selector

This block drives the synchronization trigger that a master timer sends to its slave timers. A 3-bit mode field picks the trigger source. The available sources are:

- the software update request
- the counter enable
- the update event
- a per-event channel 1 compare pulse
- one of four output-compare reference waveforms

The selected source is registered, so the trigger output is clean and arrives one clock after its source.

The same block conditions the first timer input. A select bit either passes channel pin 1 straight through, or passes the XOR of channel pins 1, 2 and 3. The XOR form is the usual way to feed a rotor position sensor with three Hall inputs into a single capture channel. The mode field and the select bit are held in a small configuration register. That register loads only on a write strobe, and both fields clear on reset.

Top module: `trgo_sel`

## Requirements
- R1: While rst_ni is low, trg_o and ti1_o are 0. Reset sets the mode to 0 (binary 000) and the input-select bit to 0.
- R2: Mode 000 makes trg_o follow the software update strobe sw_upd_i.
- R3: Mode 001 makes trg_o follow the counter enable, which is the OR of cnt_en_i and gate_act_i.
- R4: Mode 010 makes trg_o follow the update event strobe upd_evt_i. The other sources have no effect in this mode.
- R5: Mode 011 raises trg_o for one cycle for every cycle in which cc1_evt_i is high. Back-to-back events give back-to-back high cycles with no gap.
- R6: Modes 100, 101, 110 and 111 make trg_o follow oc_ref_i[0], oc_ref_i[1], oc_ref_i[2] and oc_ref_i[3] respectively.
- R7: trg_o is registered. A source value present before clock edge k appears on trg_o after edge k and not before it.
- R8: cfg_mode_i is loaded only on an edge where cfg_we_i is 1. The edge that loads a new mode still registers trg_o from the old mode. The new mode drives trg_o from the following edge on. While cfg_we_i is 0, cfg_mode_i has no effect.
- R9: ti1_o is registered. With the select bit 0 it equals ch_i[0]. With the select bit 1 it equals ch_i[0]^ch_i[1]^ch_i[2].
- R10: cfg_xor_i is loaded into the select bit only on an edge where cfg_we_i is 1. While cfg_we_i is 0 it has no effect on ti1_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration load strobe |
| cfg_mode_i | input | 3 | Trigger source mode to load |
| cfg_xor_i | input | 1 | Input-select bit to load (1 selects the XOR of three pins) |
| sw_upd_i | input | 1 | Software update request strobe |
| cnt_en_i | input | 1 | Counter enable control bit |
| gate_act_i | input | 1 | Gated-mode trigger input active |
| upd_evt_i | input | 1 | Update event strobe |
| cc1_evt_i | input | 1 | Channel 1 capture or compare match strobe |
| oc_ref_i | input | 4 | Output-compare reference levels, channels 1 to 4 |
| ch_i | input | 3 | Channel pins 1 to 3 |
| trg_o | output | 1 | Registered trigger output |
| ti1_o | output | 1 | Registered first timer input |

## Verification
The hardest case to reach is the edge where a configuration write and a live source meet. The output registered on that edge must still come from the old mode, and the new mode must take over only on the next edge. The stimulus parks the block in update-event mode with the update strobe low and the first compare reference high. It then writes the compare-reference mode in one cycle and samples the output on each of the two following cycles. A second awkward case is a run of channel 1 events on consecutive cycles. That run is driven directly, to show that every event gives its own high cycle with no gap between them.

// File: rtl/trgo_pkg.sv
package trgo_pkg;
  localparam int MODE_W = 3;
  localparam int NUM_OC = 4;
  localparam int NUM_CH = 3;

  typedef enum logic [MODE_W-1:0] {
    TRG_SW_UPD    = 3'd0,
    TRG_CNT_EN    = 3'd1,
    TRG_UPD_EVT   = 3'd2,
    TRG_CC1_PULSE = 3'd3,
    TRG_OC_REF1   = 3'd4,
    TRG_OC_REF2   = 3'd5,
    TRG_OC_REF3   = 3'd6,
    TRG_OC_REF4   = 3'd7
  } trg_mode_e;
endpackage

// File: rtl/trg_cfg_reg.sv
module trg_cfg_reg
  import trgo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              xor_i,
  output trg_mode_e         mode_o,
  output logic              xor_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= TRG_SW_UPD;
      xor_o  <= 1'b0;
    end else if (we_i) begin
      mode_o <= trg_mode_e'(mode_i);
      xor_o  <= xor_i;
    end
  end

  assert_mode_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mode_o == $past(mode_i));
  assert_mode_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mode_o));
  assert_xor_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(xor_o));
endmodule

// File: rtl/trg_src_mux.sv
module trg_src_mux
  import trgo_pkg::*;
#(
  parameter int N_OC = NUM_OC
) (
  input  trg_mode_e       mode_i,
  input  logic            sw_upd_i,
  input  logic            cnt_en_i,
  input  logic            gate_act_i,
  input  logic            upd_evt_i,
  input  logic            cc1_evt_i,
  input  logic [N_OC-1:0] oc_ref_i,
  output logic            src_o
);
  localparam int OC_IDX_W = (N_OC > 1) ? $clog2(N_OC) : 1;

  logic                cnt_on;
  logic [OC_IDX_W-1:0] oc_idx;

  assign cnt_on = cnt_en_i | gate_act_i;
  assign oc_idx = mode_i[OC_IDX_W-1:0];

  always_comb begin
    case (mode_i)
      TRG_SW_UPD:    src_o = sw_upd_i;
      TRG_CNT_EN:    src_o = cnt_on;
      TRG_UPD_EVT:   src_o = upd_evt_i;
      TRG_CC1_PULSE: src_o = cc1_evt_i;
      default:       src_o = oc_ref_i[oc_idx];
    endcase
  end
endmodule

// File: rtl/trg_ti1_sel.sv
module trg_ti1_sel
  import trgo_pkg::*;
#(
  parameter int N_CH = NUM_CH
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            xor_sel_i,
  input  logic [N_CH-1:0] ch_i,
  output logic            ti1_o
);
  logic [N_CH-1:0] par;

  // running parity over the channel pins
  assign par[0] = ch_i[0];
  for (genvar g = 1; g < N_CH; g++) begin : g_par
    assign par[g] = par[g-1] ^ ch_i[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ti1_o <= 1'b0;
    else         ti1_o <= xor_sel_i ? par[N_CH-1] : ch_i[0];
  end

  assert_direct_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xor_sel_i |=> ti1_o == $past(ch_i[0]));
  assert_xor_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xor_sel_i |=> ti1_o == ^$past(ch_i));
endmodule

// File: rtl/trgo_sel.sv
module trgo_sel
  import trgo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [MODE_W-1:0] cfg_mode_i,
  input  logic              cfg_xor_i,
  input  logic              sw_upd_i,
  input  logic              cnt_en_i,
  input  logic              gate_act_i,
  input  logic              upd_evt_i,
  input  logic              cc1_evt_i,
  input  logic [NUM_OC-1:0] oc_ref_i,
  input  logic [NUM_CH-1:0] ch_i,
  output logic              trg_o,
  output logic              ti1_o
);
  trg_mode_e mode_q;
  logic      xor_q;
  logic      src;

  trg_cfg_reg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .mode_i (cfg_mode_i),
    .xor_i  (cfg_xor_i),
    .mode_o (mode_q),
    .xor_o  (xor_q)
  );

  trg_src_mux #(.N_OC(NUM_OC)) u_mux (
    .mode_i     (mode_q),
    .sw_upd_i   (sw_upd_i),
    .cnt_en_i   (cnt_en_i),
    .gate_act_i (gate_act_i),
    .upd_evt_i  (upd_evt_i),
    .cc1_evt_i  (cc1_evt_i),
    .oc_ref_i   (oc_ref_i),
    .src_o      (src)
  );

  trg_ti1_sel #(.N_CH(NUM_CH)) u_ti1 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .xor_sel_i (xor_q),
    .ch_i      (ch_i),
    .ti1_o     (ti1_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trg_o <= 1'b0;
    else         trg_o <= src;
  end

  assert_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> trg_o == $past(src));
  assert_sw_upd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == TRG_SW_UPD |=> trg_o == $past(sw_upd_i));
  assert_cnt_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == TRG_CNT_EN && (cnt_en_i || gate_act_i)) |=> trg_o);
  assert_upd_evt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == TRG_UPD_EVT |=> trg_o == $past(upd_evt_i));
  assert_cc1_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == TRG_CC1_PULSE && cc1_evt_i) |=> trg_o);
  assert_oc_ref1_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == TRG_OC_REF1 |=> trg_o == $past(oc_ref_i[0]));
  assert_oc_ref4_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == TRG_OC_REF4 |=> trg_o == $past(oc_ref_i[3]));
endmodule

// File: tb/trgo_sel_tb_top.sv
`timescale 1ns/1ps
module trgo_sel_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [2:0] cfg_mode_i = 3'd0;
  logic       cfg_xor_i = 1'b0;
  logic       sw_upd_i = 1'b0;
  logic       cnt_en_i = 1'b0;
  logic       gate_act_i = 1'b0;
  logic       upd_evt_i = 1'b0;
  logic       cc1_evt_i = 1'b0;
  logic [3:0] oc_ref_i = 4'd0;
  logic [2:0] ch_i = 3'd0;
  logic       trg_o;
  logic       ti1_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  trgo_sel dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_mode_i(cfg_mode_i),
    .cfg_xor_i(cfg_xor_i), .sw_upd_i(sw_upd_i), .cnt_en_i(cnt_en_i),
    .gate_act_i(gate_act_i), .upd_evt_i(upd_evt_i), .cc1_evt_i(cc1_evt_i),
    .oc_ref_i(oc_ref_i), .ch_i(ch_i), .trg_o(trg_o), .ti1_o(ti1_o)
  );

  // {mode[17:15], xor[14], sw_upd[13], cnt_en[12], gate[11], upd[10], cc1[9],
  //  oc_ref[8:5], ch[4:2], exp_trg[1], exp_ti1[0]}
  localparam int NV = 17;
  localparam logic [17:0] VEC [NV] = '{
    18'b000_0_1_0_0_0_0_0000_001_1_1,  // R2 sw update, R9 direct
    18'b000_0_0_1_0_1_0_0000_110_0_0,  // R2 other sources ignored
    18'b001_1_0_1_0_0_0_0000_011_1_0,  // R3 cnt_en, R9 xor
    18'b001_1_0_0_1_0_0_0000_111_1_1,  // R3 gate
    18'b001_1_1_0_0_1_0_0000_100_0_1,  // R3 both low
    18'b010_0_0_0_0_1_0_0000_000_1_0,  // R4
    18'b010_1_1_1_0_0_0_0000_010_0_1,  // R4 others ignored
    18'b011_1_0_0_0_0_1_0000_101_1_0,  // R5
    18'b011_0_0_0_0_0_0_1111_101_0_1,  // R5 no event
    18'b100_0_0_0_0_0_0_0001_000_1_0,  // R6 ref1
    18'b100_0_0_0_0_0_0_1110_000_0_0,
    18'b101_0_0_0_0_0_0_0010_000_1_0,  // R6 ref2
    18'b101_0_0_0_0_0_0_1101_000_0_0,
    18'b110_0_0_0_0_0_0_0100_000_1_0,  // R6 ref3
    18'b110_0_0_0_0_0_0_1011_000_0_0,
    18'b111_0_0_0_0_0_0_1000_000_1_0,  // R6 ref4
    18'b111_0_0_0_0_0_0_0111_000_0_0
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clr_src();
    sw_upd_i = 0; cnt_en_i = 0; gate_act_i = 0; upd_evt_i = 0; cc1_evt_i = 0;
    oc_ref_i = '0;
  endtask

  task automatic write_cfg(input logic [2:0] m, input logic x);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_mode_i = m; cfg_xor_i = x;
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 trg in reset", trg_o, 1'b0);
    chk("R1 ti1 in reset", ti1_o, 1'b0);
    rst_ni = 1;
    // default mode 000 after reset: software update drives trigger
    sw_upd_i = 1; ch_i = 3'b011;
    @(negedge clk_i);
    chk("R1 default mode 000", trg_o, 1'b1);
    chk("R1 default select direct", ti1_o, 1'b1);
    sw_upd_i = 0;
    @(negedge clk_i);
    chk("R2 strobe drops", trg_o, 1'b0);

    for (int i = 0; i < NV; i++) begin
      write_cfg(VEC[i][17:15], VEC[i][14]);
      sw_upd_i = VEC[i][13]; cnt_en_i = VEC[i][12]; gate_act_i = VEC[i][11];
      upd_evt_i = VEC[i][10]; cc1_evt_i = VEC[i][9]; oc_ref_i = VEC[i][8:5];
      ch_i = VEC[i][4:2];
      @(negedge clk_i);
      chk($sformatf("R2-6 vec %0d trg", i), trg_o, VEC[i][1]);
      chk($sformatf("R9 vec %0d ti1", i), ti1_o, VEC[i][0]);
      clr_src();
    end

    // R7: latency of exactly one edge
    write_cfg(3'b010, 1'b0);
    @(negedge clk_i);
    upd_evt_i = 1;
    #1 chk("R7 no combinational path", trg_o, 1'b0);
    @(negedge clk_i);
    upd_evt_i = 0;
    chk("R7 one edge later", trg_o, 1'b1);
    @(negedge clk_i);
    chk("R7 strobe gone", trg_o, 1'b0);

    // R5: back-to-back compare events
    write_cfg(3'b011, 1'b0);
    cc1_evt_i = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk("R5 back-to-back pulse", trg_o, 1'b1);
    end
    cc1_evt_i = 0;
    @(negedge clk_i);
    chk("R5 after burst", trg_o, 1'b0);

    // R8: write edge still uses old mode
    write_cfg(3'b010, 1'b0);
    oc_ref_i = 4'b0001;
    @(negedge clk_i);
    cfg_we_i = 1; cfg_mode_i = 3'b100;
    @(negedge clk_i);
    cfg_we_i = 0;
    chk("R8 old mode on write edge", trg_o, 1'b0);
    @(negedge clk_i);
    chk("R8 new mode next edge", trg_o, 1'b1);

    // R8/R10: cfg inputs ignored without strobe
    cfg_mode_i = 3'b010; cfg_xor_i = 1; ch_i = 3'b011;
    repeat (2) @(negedge clk_i);
    chk("R8 mode ignored without we", trg_o, 1'b1);
    chk("R10 select ignored without we", ti1_o, 1'b1);

    // R1: asynchronous reset mid-run
    rst_ni = 0;
    #1 chk("R1 async reset trg", trg_o, 1'b0);
    chk("R1 async reset ti1", ti1_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1;
    clr_src();
    sw_upd_i = 1;
    @(negedge clk_i);
    chk("R1 mode back to 000", trg_o, 1'b1);
    sw_upd_i = 0;
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule